// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is an 8-bit watchdog timer. It sits on a byte-wide register bus and advances on a tick pulse that an external interval timer supplies. The counter runs from zero up to a programmable time-out value. The tick after it reaches that value returns it to zero and produces an interrupt event. So the interrupt period is the tick period times (time-out + 1).

A mode register selects the behaviour. With the reset-select bit low, the block is a free-running periodic interrupt timer. With that bit high, each event also sends a one-cycle system reset request. Software keeps the watchdog from firing by writing the self-clearing clear bit often enough. The interrupt flag drives the interrupt request output as a level. An acknowledge input clears the flag, and so does a software write of 0 to the flag bit.

Top module: `wdt_periph`

## Requirements
- R1: After reset, the time-out value is 0xFF. The counter reads 0x00 and the mode register reads 0x00. Outputs `irq` and `rst_req` are 0.
- R2: Read data is zero unless `reg_rd` is high. When it is high, address 0x8E returns the counter and address 0x8D returns {enable[7], reset-select[6], clear[5], 4'b0000, flag[0]}. Any other address returns 0.
- R3: When enabled, a tick with counter >= time-out sets the counter to 0 and produces an event. Any other tick adds 1 to the counter. The interrupt period is therefore (time-out + 1) ticks. Only time-out values above 0x01 are supported.
- R4: With the enable bit 0, the counter holds its value and no event occurs, whether ticks arrive or not.
- R5: An event sets the flag at the same clock edge, and `irq` follows the flag. The flag is cleared by `irq_ack` or by a write to 0x8D with bit 0 equal to 0. Writing 1 to bit 0 never sets it. If a set and a clear meet in one cycle, the set wins.
- R6: When reset-select is 1, `rst_req` pulses high for exactly the one cycle after an event. When reset-select is 0, `rst_req` stays 0.
- R7: A write to 0x8D with bit 5 equal to 1 sets the counter to 0 at that edge. The clear wins over a tick in the same cycle, and that tick produces no event. Bit 5 reads 1 for the following cycle only.
- R8: A write to 0x8E loads the time-out value, which cannot be read back. A read of 0x8E returns the counter instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| tick | input | 1 | Count pulse from the interval timer |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request level |
| rst_req | output | 1 | One-cycle reset request |

## Verification
An off-by-one in the wrap compare would shift every event by one tick. `irq` and `rst_req` would then rise one cycle early or late against the bench model at the first period. Because the counter is read back on every idle cycle, a wrong count value shows up within one cycle of the tick that produced it. A lost clear, or the wrong priority between set and clear, appears as a wrong `irq` level in the cycle right after the collision.

// File: rtl/wdt_periph.sv
module wdt_periph #(
  parameter int          W         = 8,
  parameter logic [7:0]  ADDR_TMO  = 8'h8E,
  parameter logic [7:0]  ADDR_MODE = 8'h8D,
  parameter logic [W-1:0] TMO_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [7:0]   reg_wdata,
  output logic [7:0]   reg_rdata,
  input  logic         tick,
  input  logic         irq_ack,
  output logic         irq,
  output logic         rst_req
);

  logic [W-1:0] cnt, tmo;
  logic en, rsel, clr_bit, flag;

  wire wr_mode = reg_wr && (reg_addr == ADDR_MODE);
  wire wr_tmo  = reg_wr && (reg_addr == ADDR_TMO);
  wire clr_hit = wr_mode && reg_wdata[5];
  wire ev      = en && tick && !clr_hit && (cnt >= tmo);
  wire fl_clr  = irq_ack || (wr_mode && !reg_wdata[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= TMO_INIT;
      en <= 1'b0;
      rsel <= 1'b0;
      clr_bit <= 1'b0;
      flag <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_tmo) tmo <= reg_wdata[W-1:0];
      if (wr_mode) begin
        en   <= reg_wdata[7];
        rsel <= reg_wdata[6];
      end
      clr_bit <= clr_hit;
      if (clr_hit)         cnt <= '0;
      else if (en && tick) cnt <= ev ? '0 : cnt + 1'b1;
      if (ev)          flag <= 1'b1;
      else if (fl_clr) flag <= 1'b0;
      rst_req <= ev && rsel;
    end
  end

  assign irq = flag;

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_TMO)       reg_rdata[W-1:0] = cnt;
      else if (reg_addr == ADDR_MODE) reg_rdata = {en, rsel, clr_bit, 4'b0000, flag};
    end
  end

  // R6
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) rst_req |-> flag);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!en && !clr_hit) |=> $stable(cnt));
  // R5
  flag_rose_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(tick && en));
  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) clr_bit |-> (cnt == '0));

endmodule

// File: tb/wdt_periph_tb_top.sv
module wdt_periph_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reg_addr = 8'h8E, reg_wdata = 8'h00, reg_rdata;
  logic reg_wr = 1'b0, reg_rd = 1'b1, tick = 1'b0, irq_ack = 1'b0;
  logic irq, rst_req;

  always #10 clk = ~clk;

  wdt_periph dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick(tick), .irq_ack(irq_ack), .irq(irq), .rst_req(rst_req)
  );

  int checks = 0, fails = 0;
  int m_cnt, m_tmo, m_en, m_rsel, m_clr, m_flag, m_rst;
  string tag = "R1";
  int rst_seen = 0, irq_rises = 0;

  function automatic int exp_rdata();
    if (!reg_rd) return 0;
    if (reg_addr == 8'h8E) return m_cnt;
    if (reg_addr == 8'h8D) return m_en*128 + m_rsel*64 + m_clr*32 + m_flag;
    return 0;
  endfunction

  task automatic chk(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  task automatic cyc();
    int wm, wt, ch, ev, prev_flag;
    @(posedge clk);
    prev_flag = m_flag;
    if (!rst_n) begin
      m_cnt = 0; m_tmo = 255; m_en = 0; m_rsel = 0; m_clr = 0; m_flag = 0; m_rst = 0;
    end else begin
      wm = (reg_wr && reg_addr == 8'h8D) ? 1 : 0;
      wt = (reg_wr && reg_addr == 8'h8E) ? 1 : 0;
      ch = (wm && reg_wdata[5]) ? 1 : 0;
      ev = (m_en && tick && !ch && m_cnt >= m_tmo) ? 1 : 0;
      m_rst = (ev && m_rsel) ? 1 : 0;
      if (ev) m_flag = 1;
      else if (irq_ack || (wm && !reg_wdata[0])) m_flag = 0;
      if (ch) m_cnt = 0;
      else if (m_en && tick) m_cnt = ev ? 0 : m_cnt + 1;
      m_clr = ch;
      if (wt) m_tmo = int'(reg_wdata);
      if (wm) begin m_en = reg_wdata[7]; m_rsel = reg_wdata[6]; end
    end
    if (m_rst) rst_seen++;
    if (m_flag && !prev_flag) irq_rises++;
    @(negedge clk);
    chk("R5", "irq", int'(irq), m_flag);
    chk("R6", "rst_req", int'(rst_req), m_rst);
    chk(tag, "rdata", int'(reg_rdata), exp_rdata());
    reg_wr = 0; tick = 0; irq_ack = 0; reg_rd = 1; reg_addr = 8'h8E;
  endtask

  task automatic wreg(logic [7:0] a, logic [7:0] d, logic tk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick = tk;
    cyc();
  endtask

  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = (i % gap == 0);
      cyc();
    end
  endtask

  task automatic rdmode();
    reg_addr = 8'h8D;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    cyc(); cyc();
    rst_n = 1;
    cyc();
    rdmode();
    chk("R1", "reset mode", int'(reg_rdata), 0);
    // R8: short time-out, then enable free-running
    tag = "R8";
    wreg(8'h8E, 8'h03, 0);
    tag = "R3";
    wreg(8'h8D, 8'h80, 0);
    run(20, 1);
    run(30, 3);
    chk("R3", "periodic events seen", irq_rises >= 1 ? 1 : 0, 1);
    // R5: acknowledge and software clear, write 1 no set
    tag = "R5";
    irq_ack = 1; cyc();
    wreg(8'h8D, 8'h81, 0);
    rdmode();
    run(4, 1);
    wreg(8'h8D, 8'h80, 0);
    rdmode();
    // R5 set wins: tick at wrap with ack
    run(2, 1);
    while (m_cnt != 3) run(1, 1);
    tick = 1; irq_ack = 1; cyc();
    chk("R5", "set wins irq", int'(irq), 1);
    // R4 disabled hold
    tag = "R4";
    wreg(8'h8D, 8'h00, 0);
    run(25, 1);
    rdmode();
    // R6 reset mode
    tag = "R6";
    wreg(8'h8E, 8'h05, 0);
    wreg(8'h8D, 8'hC0, 0);
    run(40, 1);
    run(30, 2);
    chk("R6", "reset pulses seen", rst_seen >= 2 ? 1 : 0, 1);
    // R7 clear with tick collision
    tag = "R7";
    run(3, 1);
    wreg(8'h8D, 8'hE0, 1);
    rdmode();
    rdmode();
    while (m_cnt != 5) run(1, 1);
    wreg(8'h8D, 8'hE0, 1);
    rdmode();
    // R3 time-out lowered below counter
    tag = "R3";
    wreg(8'h8D, 8'h80, 0);
    wreg(8'h8E, 8'h20, 0);
    run(12, 1);
    wreg(8'h8E, 8'h04, 1);
    run(300, 1);
    // R2 other addresses and rd low
    tag = "R2";
    reg_addr = 8'h10; cyc();
    reg_rd = 0; cyc();
    reg_rd = 0; reg_addr = 8'h8D; cyc();
    run(8, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule